// File: doc/BRIEF.md
# Dual Parallel Port Register File

This block is the CPU-facing register file for two 8-bit general-purpose parallel ports. A small synchronous bus (select, 2-bit address, read and write strobes, write data, registered read data) reaches four registers: one data address and one control address per port. Behind each data address sit two registers: a direction register that sets each pin as input or output, and an output latch. A select bit in the port's control register decides which of the two the data address reaches.

Each port drives its pins from the output latch masked by the direction register, and its output-enable vector follows the direction register. A read of the output latch returns a mix. Bits set as outputs give the latched value. Bits set as inputs give the live pin level. Status flags from an external interrupt unit show in the top two control bits, and the bus cannot write them. A one-cycle strobe per port tells that unit when the output latch was read, so it can clear its flags. A matching strobe marks writes to the output latch.

A bus state machine tracks the previous cycle's access. It has three states. `BUS_IDLE` means no access was taken. `BUS_RD` means a read was taken. `BUS_WR` means a write was taken. On every clock it moves to `BUS_WR` when select and write are both high. Otherwise it moves to `BUS_RD` when select and read are both high. In all other cases it returns to `BUS_IDLE`. Any state can reach any other state in one edge. The per-port strobes are decoded only in `BUS_RD` and `BUS_WR`.

Top module: `ppio_regs`

## Requirements
- R1: After reset every direction register, output latch and writable control field is 0. Both output-enable vectors and both pin-drive vectors are 0, `rdata` is 0 and no strobe is high.
- R2: Address 0 reaches port A data, 1 port B data, 2 port A control and 3 port B control. An access to one port leaves the other port's registers unchanged.
- R3: While control bit 2 of a port is 0, a write to its data address loads the direction register, and a read of that address returns the direction register.
- R4: While control bit 2 is 1, a write to the data address loads the output latch and leaves the direction register unchanged.
- R5: `*_oe` equals the direction register, and `*_out` equals output latch AND direction register, bit by bit (1 = output).
- R6: While control bit 2 is 1, a read of the data address returns, per bit, the latched value where the direction bit is 1 and the pin input where it is 0.
- R7: A control read returns the two flag inputs in bits 7 (flags[1]) and 6 (flags[0]) and the stored field in bits 5..0. A control write updates only bits 5..0.
- R8: `rdata` takes the addressed value at the clock edge that samples a read access, and holds it at every other edge.
- R9: `out_rd_pulse[p]` (bit 0 = port A, bit 1 = port B) is high for exactly the one cycle after a read of port p's output latch. It stays low for direction-register reads, control reads and idle cycles.
- R10: `out_wr_pulse[p]` is high for exactly the one cycle after a write to port p's output latch. It stays low for direction-register writes and control writes.
- R11: With select low, read and write have no effect. With read and write both high, the cycle is taken as a write only, and `rdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Block select |
| addr | input | 2 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A pin drive values |
| pa_oe | output | 8 | Port A output enables |
| pa_flags | input | 2 | Port A status flags for control bits 7..6 |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B pin drive values |
| pb_oe | output | 8 | Port B output enables |
| pb_flags | input | 2 | Port B status flags for control bits 7..6 |
| out_rd_pulse | output | 2 | Per-port strobe: output latch was read |
| out_wr_pulse | output | 2 | Per-port strobe: output latch was written |

## Verification
The assertions assume that every bus input, pin input and flag input is settled and free of X at each rising edge. They also assume that each sampled cycle holds at most one access. A cycle with both strobes high counts as one write. The bench changes all inputs only on falling edges. It ends each access with a cycle in which select is low, so each strobe-pulse window and each read-data hold window can be seen in isolation. It sweeps all 256 direction patterns on both ports.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
    localparam int NPORT      = 2;
    localparam int REG_ADDR_W = 2;
    localparam int CTL_W      = 8;
    localparam int CTL_WR_W   = 6;
    localparam int SEL_BIT    = 2;

    localparam logic [REG_ADDR_W-1:0] ADR_DATA_A = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADR_DATA_B = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADR_CTRL_A = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADR_CTRL_B = 2'd3;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_WR   = 2'd2
    } bus_state_e;
endpackage

// File: rtl/ppio_bus_fsm.sv
module ppio_bus_fsm
    import ppio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [NPORT-1:0]      sel_out,
    output logic                  rd_take,
    output logic                  wr_take,
    output logic [NPORT-1:0]      out_rd_pulse,
    output logic [NPORT-1:0]      out_wr_pulse
);
    bus_state_e       state_q, state_d;
    logic [NPORT-1:0] hit_d, hit_q;

    assign wr_take = cs & wr;
    assign rd_take = cs & rd & ~wr;

    always_comb begin
        if (wr_take)      state_d = BUS_WR;
        else if (rd_take) state_d = BUS_RD;
        else              state_d = BUS_IDLE;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_hit
        localparam logic [REG_ADDR_W-1:0] DADR = REG_ADDR_W'(p);
        assign hit_d[p] = (addr == DADR) && sel_out[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            hit_q   <= '0;
        end else begin
            state_q <= state_d;
            hit_q   <= hit_d;
        end
    end

    always_comb begin
        out_rd_pulse = '0;
        out_wr_pulse = '0;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_RD:   out_rd_pulse = hit_q;
            BUS_WR:   out_wr_pulse = hit_q;
            default:  ;
        endcase
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        localparam logic [REG_ADDR_W-1:0] DADR = REG_ADDR_W'(p);
        p_rd_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cs && rd && !wr && addr == DADR && sel_out[p]) |=> out_rd_pulse[p]);
        p_wr_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (cs && wr && addr == DADR && sel_out[p]) |=> out_wr_pulse[p]);
        p_ddr_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cs && (rd || wr) && addr == DADR && !sel_out[p])
                |=> !out_rd_pulse[p] && !out_wr_pulse[p]);
    end

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && (rd || wr)) |=> (out_rd_pulse == '0) && (out_wr_pulse == '0));
endmodule

// File: rtl/ppio_port.sv
module ppio_port
    import ppio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata,
    input  logic         data_we,
    input  logic         ctrl_we,
    input  logic [1:0]   flags,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] data_rdval,
    output logic [W-1:0] ctrl_rdval,
    output logic         sel_out
);
    logic [W-1:0]        ddr_q;
    logic [W-1:0]        out_q;
    logic [CTL_WR_W-1:0] ctl_q;
    logic [W-1:0]        live_mix;

    assign sel_out = ctl_q[SEL_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ddr_q <= '0;
            out_q <= '0;
            ctl_q <= '0;
        end else begin
            if (data_we && !sel_out) ddr_q <= wdata;
            if (data_we && sel_out)  out_q <= wdata;
            if (ctrl_we)             ctl_q <= wdata[CTL_WR_W-1:0];
        end
    end

    assign pin_oe   = ddr_q;
    assign pin_out  = out_q & ddr_q;
    assign live_mix = (pin_in & ~ddr_q) | (out_q & ddr_q);

    always_comb begin
        data_rdval = sel_out ? live_mix : ddr_q;
        ctrl_rdval = '0;
        ctrl_rdval[CTL_W-1:0] = {flags, ctl_q};
    end

    p_ddr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !sel_out) |=> pin_oe == $past(wdata));
    p_ddr_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && sel_out) |=> $stable(pin_oe));
    p_ctl_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_rdval[CTL_WR_W-1:0] == $past(wdata[CTL_WR_W-1:0]));
    p_ctl_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdval[CTL_W-1:CTL_W-2] == flags);
endmodule

// File: rtl/ppio_regs.sv
module ppio_regs
    import ppio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [DATA_W-1:0]     pa_in,
    output logic [DATA_W-1:0]     pa_out,
    output logic [DATA_W-1:0]     pa_oe,
    input  logic [1:0]            pa_flags,
    input  logic [DATA_W-1:0]     pb_in,
    output logic [DATA_W-1:0]     pb_out,
    output logic [DATA_W-1:0]     pb_oe,
    input  logic [1:0]            pb_flags,
    output logic [NPORT-1:0]      out_rd_pulse,
    output logic [NPORT-1:0]      out_wr_pulse
);
    logic              rd_take, wr_take;
    logic [NPORT-1:0]  sel_out, data_we, ctrl_we;
    logic [DATA_W-1:0] pin_in  [NPORT];
    logic [DATA_W-1:0] pin_out [NPORT];
    logic [DATA_W-1:0] pin_oe  [NPORT];
    logic [DATA_W-1:0] data_rv [NPORT];
    logic [DATA_W-1:0] ctrl_rv [NPORT];
    logic [1:0]        flags   [NPORT];
    logic [DATA_W-1:0] rd_mux;

    assign pin_in[0] = pa_in;
    assign pin_in[1] = pb_in;
    assign flags[0]  = pa_flags;
    assign flags[1]  = pb_flags;
    assign pa_out    = pin_out[0];
    assign pa_oe     = pin_oe[0];
    assign pb_out    = pin_out[1];
    assign pb_oe     = pin_oe[1];

    ppio_bus_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs           (cs),
        .rd           (rd),
        .wr           (wr),
        .addr         (addr),
        .sel_out      (sel_out),
        .rd_take      (rd_take),
        .wr_take      (wr_take),
        .out_rd_pulse (out_rd_pulse),
        .out_wr_pulse (out_wr_pulse)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam logic [REG_ADDR_W-1:0] DADR = REG_ADDR_W'(p);
        localparam logic [REG_ADDR_W-1:0] CADR = REG_ADDR_W'(p + NPORT);

        assign data_we[p] = wr_take && (addr == DADR);
        assign ctrl_we[p] = wr_take && (addr == CADR);

        ppio_port #(.W(DATA_W)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .wdata      (wdata),
            .data_we    (data_we[p]),
            .ctrl_we    (ctrl_we[p]),
            .flags      (flags[p]),
            .pin_in     (pin_in[p]),
            .pin_out    (pin_out[p]),
            .pin_oe     (pin_oe[p]),
            .data_rdval (data_rv[p]),
            .ctrl_rdval (ctrl_rv[p]),
            .sel_out    (sel_out[p])
        );
    end

    always_comb begin
        unique case (addr)
            ADR_DATA_A: rd_mux = data_rv[0];
            ADR_DATA_B: rd_mux = data_rv[1];
            ADR_CTRL_A: rd_mux = ctrl_rv[0];
            ADR_CTRL_B: rd_mux = ctrl_rv[1];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata <= '0;
        else if (rd_take) rdata <= rd_mux;
    end

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd && !wr) |=> $stable(rdata));
    p_other_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && (addr == ADR_DATA_A || addr == ADR_CTRL_A)) |=> $stable(pb_oe));
endmodule

// File: tb/ppio_regs_tb_top.sv
module ppio_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_in = '0, pb_in = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
    logic [1:0] pa_flags = '0, pb_flags = '0;
    logic [1:0] out_rd_pulse, out_wr_pulse;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    ppio_regs dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_flags(pa_flags),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_flags(pb_flags),
        .out_rd_pulse(out_rd_pulse), .out_wr_pulse(out_wr_pulse)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1; wr = 1; rd = 0; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1; rd = 1; wr = 0; addr = a;
        @(negedge clk);
        cs = 0; rd = 0;
        d = rdata;
    endtask

    function automatic logic [7:0] oe_of(input int p);
        return (p == 0) ? pa_oe : pb_oe;
    endfunction

    function automatic logic [7:0] out_of(input int p);
        return (p == 0) ? pa_out : pb_out;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv, held, o, pin, c;
        logic [7:0] ddr_m [2];
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pa_out", pa_out, 8'h00);
        chk("R1 pb_out", pb_out, 8'h00);
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 pulses", {4'h0, out_rd_pulse, out_wr_pulse}, 8'h00);
        rst_n = 1;
        for (int a = 0; a < 4; a++) begin
            bus_rd(2'(a), rv);
            chk("R1 reg read", rv, 8'h00);
        end
        ddr_m[0] = 8'h00; ddr_m[1] = 8'h00;

        // R2..R7, R9, R10 sweep over every direction pattern on both ports
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] dv;
                dv = 8'(v);
                bus_wr(2'(p), dv);
                ddr_m[p] = dv;
                chk("R3 ddr to oe", oe_of(p), dv);
                chk("R10 no strobe on ddr write", {6'h0, out_wr_pulse}, 8'h00);
                chk("R2 other port kept", oe_of(1 - p), ddr_m[1 - p]);
                bus_rd(2'(p), rv);
                chk("R3 ddr readback", rv, dv);
                chk("R9 no strobe on ddr read", {6'h0, out_rd_pulse}, 8'h00);

                if (p == 0) pa_flags = dv[1:0]; else pb_flags = dv[1:0];
                c = dv ^ 8'hA5;
                c[2] = 1'b1;
                bus_wr(2'(p + 2), c);
                bus_rd(2'(p + 2), rv);
                chk("R7 control read", rv, {dv[1:0], c[5:0]});
                chk("R9 no strobe on ctrl read", {6'h0, out_rd_pulse}, 8'h00);

                o = dv ^ 8'h5A;
                bus_wr(2'(p), o);
                chk("R10 wr strobe", {6'h0, out_wr_pulse}, 8'(1 << p));
                chk("R4 ddr unchanged", oe_of(p), dv);
                chk("R5 pin drive", out_of(p), o & dv);
                @(negedge clk);
                chk("R10 strobe one cycle", {6'h0, out_wr_pulse}, 8'h00);

                pin = 8'(v * 37 + 11);
                if (p == 0) pa_in = pin; else pb_in = pin;
                bus_rd(2'(p), rv);
                chk("R6 mixed read", rv, (pin & ~dv) | (o & dv));
                chk("R9 rd strobe", {6'h0, out_rd_pulse}, 8'(1 << p));
                @(negedge clk);
                chk("R9 strobe one cycle", {6'h0, out_rd_pulse}, 8'h00);
                chk("R8 rdata held", rdata, (pin & ~dv) | (o & dv));

                c[2] = 1'b0;
                bus_wr(2'(p + 2), c);
            end
        end

        // R11: select low ignores strobes
        held = rdata;
        @(negedge clk);
        cs = 0; rd = 1; wr = 1; addr = 2'd0; wdata = 8'h3C;
        @(negedge clk);
        rd = 0; wr = 0;
        chk("R11 no cs: oe kept", pa_oe, ddr_m[0]);
        chk("R11 no cs: rdata kept", rdata, held);
        chk("R11 no cs: no strobe", {4'h0, out_rd_pulse, out_wr_pulse}, 8'h00);

        // R11: read and write together on port A output latch
        bus_wr(2'd0, 8'hF0);
        ddr_m[0] = 8'hF0;
        bus_wr(2'd2, 8'h04);
        bus_rd(2'd3, rv);
        held = rv;
        @(negedge clk);
        cs = 1; rd = 1; wr = 1; addr = 2'd0; wdata = 8'hCC;
        @(negedge clk);
        cs = 0; rd = 0; wr = 0;
        chk("R11 both: write done", pa_out, 8'hC0);
        chk("R11 both: rdata held", rdata, held);
        chk("R11 both: wr strobe only", {4'h0, out_rd_pulse, out_wr_pulse}, 8'h01);

        // R7: control bits 7..6 not writable, follow flags
        pa_flags = 2'b10;
        bus_wr(2'd2, 8'hFF);
        bus_rd(2'd2, rv);
        chk("R7 flags read-only", rv, 8'hBF);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule